// File: doc/BRIEF.md
# Receive Control and Status Unit

This block sits between a host register port and a frame receive engine. A host-writable control register produces two level-sensitive reset requests: one for the receive engine and one for the receive FIFO. It also holds a start bit whose rising edge launches one reception. A read-only status view reports whether a reception is in progress and whether either of two CRC checkers (a 32-bit one and an 8-bit one) has reported a good result. For each checker the block also keeps the value of the running byte count at the moment that checker reported good.

The start bit is edge-triggered. To begin another reception the host must write it to 0 and then to 1 again. Clearing it during a reception does not stop that reception. The only way to abort is the receive reset bit, and that reset does not touch the FIFO reset. Host-side FIFO DMA requests are produced elsewhere and do not depend on the start bit.

Top module: `rx_ctl_stat`

## Requirements
- R1: After reset, all control bits are 0, `ctrl_rdata` and `stat_rdata` read 0x00, both reset outputs are low, `rx_start_pulse` and `rx_busy` are low, and both latched counts are 0.
- R2: Control bit 7 is stored when `ctrl_we` is sampled high. `rx_rst` equals that stored bit from the clock edge of the write onward, and it reads back in bit 7 of `ctrl_rdata`.
- R3: Control bit 6 drives `rxfifo_rst` in the same way and reads back in bit 6. Setting bit 7 alone leaves `rxfifo_rst` low.
- R4: Control bits 5:1 are stored as 0 whatever is written. Bit 0 reads back the start bit.
- R5: A write that changes the start bit (bit 0) from 0 to 1, while bit 7 is 0 and no reception is busy, raises `rx_start_pulse` for exactly one cycle, starting at the write's clock edge. `rx_busy` is 1 from the next edge onward.
- R6: Writing 1 to a start bit that already holds 1 produces no pulse. A 0 write followed by a 1 write is needed.
- R7: Writing the start bit to 0 during a reception leaves `rx_busy` at 1.
- R8: `rx_done` sampled high while busy clears `rx_busy` at that edge.
- R9: While bit 7 is 1, `rx_busy`, both CRC flags and both latched counts are held at 0, and no start pulse is produced. Releasing bit 7 while the start bit is still 1 produces no pulse.
- R10: `crc32_ok` sampled high while busy sets status bit 7 and loads `crc32_cnt` with `byte_cnt` from that same edge. A later hit reloads the count. Hits while idle are ignored.
- R11: `crc8_ok` sampled high while busy sets status bit 6 and loads `crc8_cnt` in the same way, independently of the 32-bit checker.
- R12: A start pulse clears both CRC flags and both latched counts. Status bit 0 shows `rx_busy`, and status bits 5:1 read 0.
- R13: A start-bit rising edge that arrives while a reception is busy produces no pulse and is not held over for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| crc32_ok | input | 1 | 32-bit CRC checked good (pulse) |
| crc8_ok | input | 1 | 8-bit CRC checked good (pulse) |
| byte_cnt | input | CNT_W | Running receive byte count |
| rx_done | input | 1 | Reception finished (pulse) |
| ctrl_rdata | output | 8 | Control register readback |
| stat_rdata | output | 8 | Status: bit7 CRC-32 good, bit6 CRC-8 good, bit0 busy |
| rx_rst | output | 1 | Receive engine reset request |
| rxfifo_rst | output | 1 | Receive FIFO reset request |
| rx_start_pulse | output | 1 | One-cycle reception launch |
| rx_busy | output | 1 | Reception in progress |
| crc32_cnt | output | CNT_W | Byte count latched at last CRC-32 good |
| crc8_cnt | output | CNT_W | Byte count latched at last CRC-8 good |

## Verification
The start bit is driven with several patterns: a clean 0-to-1 write, a repeated 1 write, a 1 write while busy, and a 1 write made while the receive reset is held. Together these separate a true edge detector from a level detector, and from one that remembers edges it has suppressed. CRC pulses are applied while busy, while idle, and more than once in one reception, with different byte counts each time. This shows that the counts are captured at the edge, that they are gated by busy, and that a later hit overwrites an earlier one. Writes that set the reset bits one at a time, and writes full of reserved 1s, show that the two resets are independent and that reserved bits are masked.

// File: rtl/rxcs_pkg.sv
package rxcs_pkg;
   localparam int REG_W      = 8;
   localparam int CTL_RST    = 7;
   localparam int CTL_FRST   = 6;
   localparam int CTL_GO     = 0;
   localparam int STS_C32    = 7;
   localparam int STS_C8     = 6;
   localparam int STS_BUSY   = 0;
   localparam logic [REG_W-1:0] CTL_KEEP =
      (REG_W'(1) << CTL_RST) | (REG_W'(1) << CTL_FRST) | (REG_W'(1) << CTL_GO);
endpackage

// File: rtl/rxcs_ctrl_reg.sv
module rxcs_ctrl_reg
   import rxcs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] ctrl_q,
   output logic             go_rise
);
   logic go_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         go_d   <= 1'b0;
      end else begin
         go_d <= ctrl_q[CTL_GO];
         if (we) ctrl_q <= wdata & CTL_KEEP;
      end
   end

   assign go_rise = ctrl_q[CTL_GO] & ~go_d;
endmodule

// File: rtl/rxcs_busy.sv
module rxcs_busy (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic go_rise,
   input  logic done,
   output logic start_pulse,
   output logic busy
);
   assign start_pulse = go_rise & ~abort & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n || abort) busy <= 1'b0;
      else if (start_pulse) busy <= 1'b1;
      else if (done)        busy <= 1'b0;
   end
endmodule

// File: rtl/rxcs_crc_latch.sv
module rxcs_crc_latch #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             arm,
   input  logic             hit,
   input  logic [CNT_W-1:0] cnt,
   output logic             flag,
   output logic [CNT_W-1:0] cnt_q
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         flag  <= 1'b0;
         cnt_q <= '0;
      end else if (arm && hit) begin
         flag  <= 1'b1;
         cnt_q <= cnt;
      end
   end
endmodule

// File: rtl/rx_ctl_stat.sv
module rx_ctl_stat
   import rxcs_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter int NUM_CRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic [7:0]       ctrl_wdata,
   input  logic             crc32_ok,
   input  logic             crc8_ok,
   input  logic [CNT_W-1:0] byte_cnt,
   input  logic             rx_done,
   output logic [7:0]       ctrl_rdata,
   output logic [7:0]       stat_rdata,
   output logic             rx_rst,
   output logic             rxfifo_rst,
   output logic             rx_start_pulse,
   output logic             rx_busy,
   output logic [CNT_W-1:0] crc32_cnt,
   output logic [CNT_W-1:0] crc8_cnt
);
   localparam int CW = CNT_W;

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_w
      $error("rx_ctl_stat: CNT_W out of range");
   end
   if (NUM_CRC != 2) begin : g_bad_n
      $error("rx_ctl_stat: NUM_CRC must be 2");
   end

   logic [REG_W-1:0]   ctrl_q;
   logic               go_rise;
   logic               clr_crc;
   logic [NUM_CRC-1:0] hit_v;
   logic [NUM_CRC-1:0] flag_v;
   logic [CW-1:0]      cnt_v [NUM_CRC];

   rxcs_ctrl_reg u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
      .ctrl_q(ctrl_q), .go_rise(go_rise)
   );

   assign rx_rst     = ctrl_q[CTL_RST];
   assign rxfifo_rst = ctrl_q[CTL_FRST];
   assign ctrl_rdata = ctrl_q;

   rxcs_busy u_busy (
      .clk(clk), .rst_n(rst_n), .abort(rx_rst), .go_rise(go_rise),
      .done(rx_done), .start_pulse(rx_start_pulse), .busy(rx_busy)
   );

   assign clr_crc = rx_rst | rx_start_pulse;
   assign hit_v   = {crc8_ok, crc32_ok};

   for (genvar g = 0; g < NUM_CRC; g++) begin : g_crc
      rxcs_crc_latch #(.CNT_W(CW)) u_lat (
         .clk(clk), .rst_n(rst_n), .clr(clr_crc), .arm(rx_busy),
         .hit(hit_v[g]), .cnt(byte_cnt), .flag(flag_v[g]), .cnt_q(cnt_v[g])
      );
   end

   assign crc32_cnt = cnt_v[0];
   assign crc8_cnt  = cnt_v[1];

   always_comb begin
      stat_rdata           = '0;
      stat_rdata[STS_C32]  = flag_v[0];
      stat_rdata[STS_C8]   = flag_v[1];
      stat_rdata[STS_BUSY] = rx_busy;
   end
endmodule

// File: rtl/rx_ctl_stat_chk.sv
module rx_ctl_stat_chk #(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             crc32_ok,
   input logic [CNT_W-1:0] byte_cnt,
   input logic             rx_done,
   input logic [7:0]       stat_rdata,
   input logic             rx_rst,
   input logic             rx_start_pulse,
   input logic             rx_busy,
   input logic [CNT_W-1:0] crc32_cnt,
   input logic [CNT_W-1:0] crc8_cnt
);
   // R5
   start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_start_pulse |=> !rx_start_pulse);
   // R5
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_start_pulse && !rx_rst |=> rx_busy);
   // R13
   no_start_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy |-> !rx_start_pulse);
   // R8
   done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy && rx_done |=> !rx_busy);
   // R9
   reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rst |=> !rx_busy && stat_rdata[7:6] == 2'b00 && crc32_cnt == '0 && crc8_cnt == '0);
   // R10
   crc32_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy && crc32_ok && !rx_rst |=> stat_rdata[7] && crc32_cnt == $past(byte_cnt));
endmodule

bind rx_ctl_stat rx_ctl_stat_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .crc32_ok(crc32_ok), .byte_cnt(byte_cnt),
   .rx_done(rx_done), .stat_rdata(stat_rdata), .rx_rst(rx_rst),
   .rx_start_pulse(rx_start_pulse), .rx_busy(rx_busy),
   .crc32_cnt(crc32_cnt), .crc8_cnt(crc8_cnt)
);

// File: tb/rx_ctl_stat_bench.sv
`timescale 1ns/1ps
module rx_ctl_stat_bench;
   localparam int W = 12;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctrl_we = 1'b0;
   logic [7:0] ctrl_wdata = '0;
   logic crc32_ok = 1'b0, crc8_ok = 1'b0, rx_done = 1'b0;
   logic [W-1:0] byte_cnt = '0;
   logic [7:0] ctrl_rdata, stat_rdata;
   logic rx_rst, rxfifo_rst, rx_start_pulse, rx_busy;
   logic [W-1:0] crc32_cnt, crc8_cnt;

   int errors = 0, checks = 0, cycles = 0;

   rx_ctl_stat #(.CNT_W(W)) u_rx_ctl_stat (.*);

   always #4 clk = ~clk;

   // behavioural reference
   logic [7:0] m_ctrl = '0;
   bit m_prev = 0, m_busy = 0, m_f32 = 0, m_f8 = 0;
   int m_c32 = 0, m_c8 = 0;

   function automatic bit m_pulse();
      return m_ctrl[0] && !m_prev && !m_ctrl[7] && !m_busy;
   endfunction

   always @(posedge clk) begin
      bit p;
      cycles++;
      p = m_pulse();
      if (!rst_n) begin
         m_ctrl = 0; m_prev = 0; m_busy = 0; m_f32 = 0; m_f8 = 0; m_c32 = 0; m_c8 = 0;
      end else begin
         m_prev = m_ctrl[0];
         if (m_ctrl[7] || p) begin
            m_busy = p; m_f32 = 0; m_f8 = 0; m_c32 = 0; m_c8 = 0;
         end else if (m_busy) begin
            if (crc32_ok) begin m_f32 = 1; m_c32 = int'(byte_cnt); end
            if (crc8_ok)  begin m_f8 = 1;  m_c8  = int'(byte_cnt); end
            if (rx_done) m_busy = 0;
         end
         if (ctrl_we) m_ctrl = ctrl_wdata & 8'hC1;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare();
      chk("R2 rx_rst", int'(rx_rst), int'(m_ctrl[7]));
      chk("R3 rxfifo_rst", int'(rxfifo_rst), int'(m_ctrl[6]));
      chk("R4 ctrl_rdata", int'(ctrl_rdata), int'(m_ctrl));
      chk("R5 start pulse", int'(rx_start_pulse), int'(m_pulse()));
      chk("R8 busy", int'(rx_busy), int'(m_busy));
      chk("R12 status", int'(stat_rdata), (int'(m_f32) << 7) | (int'(m_f8) << 6) | int'(m_busy));
      chk("R10 crc32_cnt", int'(crc32_cnt), m_c32);
      chk("R11 crc8_cnt", int'(crc8_cnt), m_c8);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      compare();
      ctrl_we = 0; crc32_ok = 0; crc8_ok = 0; rx_done = 0;
   endtask

   task automatic wr(logic [7:0] d);
      ctrl_we = 1; ctrl_wdata = d;
      tick();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      // R1 reset state
      chk("R1 ctrl", int'(ctrl_rdata), 0);
      chk("R1 stat", int'(stat_rdata), 0);
      chk("R1 resets", int'({rx_rst, rxfifo_rst, rx_start_pulse, rx_busy}), 0);
      chk("R1 counts", int'(crc32_cnt) + int'(crc8_cnt), 0);
      idle(2);

      // R10 idle hits ignored
      byte_cnt = 12'h033; crc32_ok = 1; crc8_ok = 1; tick();
      chk("R10 idle hit ignored", int'(stat_rdata), 0);

      // R5 clean start
      wr(8'h01);
      chk("R5 pulse on write", int'(rx_start_pulse), 1);
      tick();
      chk("R5 busy next", int'(rx_busy), 1);
      chk("R5 pulse single", int'(rx_start_pulse), 0);
      byte_cnt = 12'h005; crc8_ok = 1; tick();
      chk("R11 crc8 latched", int'(crc8_cnt), 5);
      byte_cnt = 12'h009; crc32_ok = 1; tick();
      byte_cnt = 12'h00C; crc32_ok = 1; tick();
      chk("R10 crc32 reload", int'(crc32_cnt), 12'h00C);
      // R6 repeated 1 write
      wr(8'h01);
      chk("R6 no pulse on level", int'(rx_start_pulse), 0);
      // R7 clear start mid-reception
      wr(8'h00); tick();
      chk("R7 busy kept", int'(rx_busy), 1);
      // R13 edge while busy ignored
      wr(8'h01);
      chk("R13 no pulse while busy", int'(rx_start_pulse), 0);
      rx_done = 1; tick();
      chk("R8 done clears busy", int'(rx_busy), 0);
      idle(2);
      chk("R13 edge not held", int'(rx_busy), 0);
      chk("R12 flags kept after done", int'(stat_rdata), 8'hC0);

      // R12 new start clears flags
      wr(8'h00); wr(8'h01); tick();
      chk("R12 flags cleared", int'(stat_rdata), 8'h01);
      chk("R12 counts cleared", int'(crc32_cnt) + int'(crc8_cnt), 0);
      byte_cnt = 12'hABC; crc32_ok = 1; crc8_ok = 1; rx_done = 1; tick();
      chk("R10 hit with done", int'(crc32_cnt), 12'hABC);

      // R9 receive reset
      wr(8'h00); wr(8'h01); tick();
      byte_cnt = 12'h111; crc8_ok = 1; tick();
      wr(8'h80); tick();
      chk("R9 abort clears", int'(stat_rdata), 0);
      chk("R3 fifo reset untouched", int'(rxfifo_rst), 0);
      wr(8'h81);
      chk("R9 no start in reset", int'(rx_start_pulse), 0);
      wr(8'h01);
      chk("R9 release no pulse", int'(rx_start_pulse), 0);
      idle(2);
      chk("R9 stays idle", int'(rx_busy), 0);

      // R4 reserved bits, R3 fifo reset alone
      wr(8'hFE);
      chk("R4 reserved masked", int'(ctrl_rdata), 8'hC0);
      wr(8'h40);
      chk("R3 fifo only", int'({rx_rst, rxfifo_rst}), 1);
      wr(8'h00); wr(8'h01);
      chk("R5 start after clean edge", int'(rx_start_pulse), 1);
      idle(3);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait (cycles > 5000);
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule